// File: doc/BRIEF.md
# Keyed Watchdog with Clock-Mode Reset Pulse

This block guards a small 8-bit controller against runaway software. It watches a byte-wide special-function-register write port. It starts disarmed. A two-write key sent to one write-only register arms it, and the same key later restarts its count. While armed, a 14-bit counter advances on each machine-cycle tick. If software lets the count reach its limit, the block drives a high reset pulse. The pulse width follows the oscillator clock mode in use.

Once armed, the watchdog cannot be switched off by software. Only the external reset or its own overflow pulse returns it to the disarmed state. The count cannot be read. The only things visible at the ports are the reset pulse and an armed flag.

Top module: `keyed_watchdog`

## Requirements
- R1: After the external reset, `wd_armed` is 0 and `wd_reset` is 0. While disarmed, no number of ticks produces a pulse. The external reset also disarms an armed watchdog.
- R2: Two consecutive writes to address 0xA6 arm the watchdog: first the data 0x1E, then the data 0xE1. `wd_armed` reads 1 after the clock edge that samples the second write.
- R3: Completing the key sequence while armed restarts the count. The overflow then comes only 16383 ticks after the most recent completion.
- R4: While armed, no write to 0xA6 with any data clears `wd_armed`. Only the external reset or an overflow pulse clears it.
- R5: The count advances only on cycles where `mc_tick` is 1 and the block is armed. The overflow pulse starts at the clock edge that samples the 16383rd tick since the last arming or service.
- R6: `wd_armed` drops to 0 at the edge where the pulse starts. Key writes made during the pulse are ignored, so the block is disarmed once the pulse ends.
- R7: `wd_reset` stays 1 for exactly 98 clock cycles when `clk12_mode` is 0. It stays 1 for exactly 196 clock cycles when `clk12_mode` is 1. The mode is sampled at the overflow edge.
- R8: After 0x1E, a write to 0xA6 with any value other than 0xE1 or 0x1E cancels the pending sequence. A repeated 0x1E keeps the sequence pending as a fresh first byte.
- R9: Writes to any address other than 0xA6 leave a pending sequence intact.
- R10: If the key completes in the same cycle as the 16383rd tick, the service wins. No pulse occurs, and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | External synchronous reset, active high |
| mc_tick | input | 1 | One-cycle machine-cycle strobe |
| clk12_mode | input | 1 | 1 selects 12-clock mode, 0 selects 6-clock mode |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| wd_reset | output | 1 | Overflow reset pulse, active high |
| wd_armed | output | 1 | Watchdog armed flag |

## Verification
The count is hidden, so a counter that is off by even one tick shows only as a pulse that starts one tick early or late. The bench therefore measures the tick on which the pulse starts against its own count of ticks. A key decoder in the wrong state shows on `wd_armed` right after the edge of the second key write. A wrong pulse counter shows as a width other than 98 or 196 cycles. A disarm path that should not exist shows as `wd_armed` dropping right after the stray write.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int unsigned KWD_CNT_W     = 14;
    localparam logic [7:0]  KWD_KEY_ADDR  = 8'hA6;
    localparam logic [7:0]  KWD_KEY_FIRST = 8'h1E;
    localparam logic [7:0]  KWD_KEY_LAST  = 8'hE1;
    localparam int unsigned KWD_LEN_FAST  = 98;
    localparam int unsigned KWD_LEN_SLOW  = 196;

    typedef enum logic {
        KEY_IDLE = 1'b0,
        KEY_HALF = 1'b1
    } key_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } sfr_wr_t;

    function automatic int unsigned pulse_len(input logic slow,
                                              input int unsigned fast_len,
                                              input int unsigned slow_len);
        return slow ? slow_len : fast_len;
    endfunction

endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
    import kwd_pkg::*;
#(
    parameter logic [7:0] KEY_ADDR  = KWD_KEY_ADDR,
    parameter logic [7:0] KEY_FIRST = KWD_KEY_FIRST,
    parameter logic [7:0] KEY_LAST  = KWD_KEY_LAST
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hold,
    input  sfr_wr_t wr,
    output logic    key_ok,
    output logic    pending
);

    key_state_e state_q, state_d;
    logic       hit;

    assign hit     = wr.en && (wr.addr == KEY_ADDR) && !hold;
    assign key_ok  = hit && (state_q == KEY_HALF) && (wr.data == KEY_LAST);
    assign pending = (state_q == KEY_HALF);

    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = KEY_IDLE;
        end else if (hit) begin
            if (wr.data == KEY_FIRST) begin
                state_d = KEY_HALF;
            end else begin
                state_d = KEY_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= KEY_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R8: a stray byte on the key address drops any pending first byte
    a_r8_cancel_pending: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == KEY_ADDR && wr.data != KEY_FIRST && wr.data != KEY_LAST)
        |=> !pending);

    // R9: foreign writes keep the pending state
    a_r9_foreign_keeps: assert property (@(posedge clk) disable iff (rst)
        (pending && !hold && !(wr.en && wr.addr == KEY_ADDR)) |=> pending);

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int unsigned CNT_W = kwd_pkg::KWD_CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic clear,
    output logic ovf
);

    localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_TOP - 1'b1;

    logic [CNT_W-1:0] count_q;

    assign ovf = run && tick && !clear && (count_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || ovf) begin
            count_q <= '0;
        end else if (run && tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    // R5: the count never sits at the overflow value
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q != CNT_TOP);

    // R5: a disarmed counter rests at zero
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !run |-> count_q == '0);

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int unsigned LEN_FAST = kwd_pkg::KWD_LEN_FAST,
    parameter int unsigned LEN_SLOW = kwd_pkg::KWD_LEN_SLOW
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic slow,
    output logic active
);

    localparam int unsigned LEN_MAX = (LEN_SLOW > LEN_FAST) ? LEN_SLOW : LEN_FAST;
    localparam int unsigned PW_W    = $clog2(LEN_MAX);

    logic [PW_W-1:0] left_q;
    logic [PW_W-1:0] load_val;

    assign load_val = PW_W'(kwd_pkg::pulse_len(slow, LEN_FAST, LEN_SLOW) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            left_q <= '0;
        end else if (!active && fire) begin
            active <= 1'b1;
            left_q <= load_val;
        end else if (active) begin
            if (left_q == '0) begin
                active <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    // R7: a pulse is never a single cycle
    a_r7_min_width: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |=> active);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int unsigned CNT_W     = KWD_CNT_W,
    parameter logic [7:0]  KEY_ADDR  = KWD_KEY_ADDR,
    parameter logic [7:0]  KEY_FIRST = KWD_KEY_FIRST,
    parameter logic [7:0]  KEY_LAST  = KWD_KEY_LAST,
    parameter int unsigned LEN_FAST  = KWD_LEN_FAST,
    parameter int unsigned LEN_SLOW  = KWD_LEN_SLOW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mc_tick,
    input  logic       clk12_mode,
    input  logic       sfr_we,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    output logic       wd_reset,
    output logic       wd_armed
);

    sfr_wr_t wr;
    logic    key_ok;
    logic    key_pending;
    logic    ovf;
    logic    armed_q;

    assign wr = '{en: sfr_we, addr: sfr_addr, data: sfr_wdata};

    kwd_key_seq #(
        .KEY_ADDR (KEY_ADDR),
        .KEY_FIRST(KEY_FIRST),
        .KEY_LAST (KEY_LAST)
    ) i_key (
        .clk    (clk),
        .rst    (rst),
        .hold   (wd_reset),
        .wr     (wr),
        .key_ok (key_ok),
        .pending(key_pending)
    );

    kwd_counter #(
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (armed_q),
        .tick (mc_tick),
        .clear(key_ok),
        .ovf  (ovf)
    );

    kwd_pulse #(
        .LEN_FAST(LEN_FAST),
        .LEN_SLOW(LEN_SLOW)
    ) i_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (ovf),
        .slow  (clk12_mode),
        .active(wd_reset)
    );

    always_ff @(posedge clk) begin
        if (rst || ovf) begin
            armed_q <= 1'b0;
        end else if (key_ok) begin
            armed_q <= 1'b1;
        end
    end

    assign wd_armed = armed_q;

    // R4: software has no path that disarms the block
    a_r4_stays_armed: assert property (@(posedge clk) disable iff (rst)
        (wd_armed && !ovf) |=> wd_armed);

    // R6: the block is never armed while its pulse is out
    a_r6_pulse_disarms: assert property (@(posedge clk) disable iff (rst)
        wd_reset |-> !wd_armed);

    // R6: a pulse begins exactly where the armed flag drops without reset
    a_r6_fall_starts_pulse: assert property (@(posedge clk) disable iff (rst)
        (wd_armed && !key_ok && !$past(rst)) ##1 !wd_armed |-> $rose(wd_reset));

endmodule

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;

    localparam logic [7:0] A_KEY = 8'hA6;
    localparam int unsigned LIMIT = 16383;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mc_tick = 1'b0;
    logic       clk12_mode = 1'b0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic       wd_reset;
    logic       wd_armed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    keyed_watchdog i_keyed_watchdog (
        .clk       (clk),
        .rst       (rst),
        .mc_tick   (mc_tick),
        .clk12_mode(clk12_mode),
        .sfr_we    (sfr_we),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .wd_reset  (wd_reset),
        .wd_armed  (wd_armed)
    );

    always #5 clk = ~clk;

    function automatic int exp_width(input logic slow);
        return slow ? 196 : 98;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic we, input logic [7:0] a, input logic [7:0] d);
        mc_tick = t; sfr_we = we; sfr_addr = a; sfr_wdata = d;
        @(posedge clk);
        @(negedge clk);
        mc_tick = 1'b0; sfr_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) cyc(1'b0, 1'b0, 8'h00, 8'h00);
        rst = 1'b0;
    endtask

    task automatic send_key();
        cyc(1'b0, 1'b1, A_KEY, 8'h1E);
        cyc(1'b0, 1'b1, A_KEY, 8'hE1);
    endtask

    // runs n ticks and returns how many cycles showed the pulse
    task automatic ticks(input int n, output int seen);
        seen = 0;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 8'h00);
            if (wd_reset) seen++;
        end
    endtask

    // wd_reset is high on entry; returns the full width
    task automatic drain(output int w);
        w = 1;
        for (int i = 0; i < 400; i++) begin
            cyc(1'b0, 1'b0, 8'h00, 8'h00);
            if (!wd_reset) break;
            w++;
        end
    endtask

    initial begin
        #(1_990_000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen;
        int w;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 armed after reset", int'(wd_armed), 0);
        chk("R1 pulse after reset", int'(wd_reset), 0);
        ticks(17000, seen);
        chk("R1 no pulse while disarmed", seen, 0);

        // R8 cancel and restart
        cyc(1'b0, 1'b1, A_KEY, 8'h1E);
        cyc(1'b0, 1'b1, A_KEY, 8'h55);
        cyc(1'b0, 1'b1, A_KEY, 8'hE1);
        chk("R8 cancelled sequence", int'(wd_armed), 0);
        cyc(1'b0, 1'b1, A_KEY, 8'h1E);
        cyc(1'b0, 1'b1, A_KEY, 8'h1E);
        cyc(1'b0, 1'b1, A_KEY, 8'hE1);
        chk("R8 repeated first byte", int'(wd_armed), 1);
        do_reset();
        chk("R1 reset disarms", int'(wd_armed), 0);

        // R9 foreign writes between key bytes
        cyc(1'b0, 1'b1, A_KEY, 8'h1E);
        cyc(1'b0, 1'b1, 8'hA5, 8'hE1);
        cyc(1'b1, 1'b1, 8'h00, 8'h00);
        chk("R9 still disarmed mid-key", int'(wd_armed), 0);
        cyc(1'b0, 1'b1, A_KEY, 8'hE1);
        chk("R9 foreign writes kept key", int'(wd_armed), 1);

        // R2 (armed after second write) and R4 no disarm
        cyc(1'b0, 1'b1, A_KEY, 8'h00);
        cyc(1'b0, 1'b1, A_KEY, 8'hFF);
        cyc(1'b0, 1'b1, A_KEY, 8'h1E);
        cyc(1'b0, 1'b1, A_KEY, 8'h55);
        chk("R4 key writes keep armed", int'(wd_armed), 1);
        do_reset();
        send_key();
        chk("R2 armed by key", int'(wd_armed), 1);

        // R5 exact overflow with idle cycles in between
        clk12_mode = 1'b0;
        seen = 0;
        for (int i = 0; i < int'(LIMIT) - 1; i++) begin
            cyc(1'b1, 1'b0, 8'h00, 8'h00);
            if (wd_reset) seen++;
            if (i % 7 == 0) begin
                cyc(1'b0, 1'b0, 8'h00, 8'h00);
                if (wd_reset) seen++;
            end
        end
        chk("R5 no pulse before last tick", seen, 0);
        cyc(1'b1, 1'b0, 8'h00, 8'h00);
        chk("R5 pulse at last tick", int'(wd_reset), 1);
        chk("R6 disarmed at pulse", int'(wd_armed), 0);
        // R6 key writes during pulse are ignored
        cyc(1'b0, 1'b1, A_KEY, 8'h1E);
        cyc(1'b0, 1'b1, A_KEY, 8'hE1);
        w = 3;
        if (wd_reset) begin
            drain(w);
            w = w + 2;
        end
        chk("R7 width in 6-clock mode", w, exp_width(1'b0));
        chk("R6 disarmed after pulse", int'(wd_armed), 0);

        // R7 12-clock width
        clk12_mode = 1'b1;
        send_key();
        ticks(LIMIT, seen);
        chk("R7 pulse rose in 12-clock", seen, 1);
        clk12_mode = 1'b0;
        drain(w);
        chk("R7 width in 12-clock mode", w, exp_width(1'b1));

        // R3 service restarts count
        send_key();
        ticks(10000, seen);
        send_key();
        ticks(10000, w);
        chk("R3 no pulse after service", seen + w, 0);
        ticks(int'(LIMIT) - 10001, seen);
        chk("R3 no pulse before limit", seen, 0);
        cyc(1'b1, 1'b0, 8'h00, 8'h00);
        chk("R3 pulse at limit after service", int'(wd_reset), 1);
        drain(w);

        // R10 service in same cycle as the final tick
        send_key();
        ticks(int'(LIMIT) - 2, seen);
        cyc(1'b1, 1'b1, A_KEY, 8'h1E);
        cyc(1'b1, 1'b1, A_KEY, 8'hE1);
        chk("R10 service beats overflow", int'(wd_reset), 0);
        chk("R10 still armed", int'(wd_armed), 1);
        ticks(int'(LIMIT) - 1, seen);
        chk("R10 count restarted", seen, 0);
        cyc(1'b1, 1'b0, 8'h00, 8'h00);
        chk("R10 overflow after restart", int'(wd_reset), 1);
        drain(w);

        // random: sparse ticks, foreign writes, periodic service
        void'($urandom(32'd4711));
        send_key();
        seen = 0;
        for (int r = 0; r < 6; r++) begin
            int gap = $urandom_range(4000, 100);
            int tk = 0;
            while (tk < gap) begin
                logic t = ($urandom_range(3, 0) != 0);
                logic we = ($urandom_range(3, 0) == 0);
                logic [7:0] a = 8'($urandom_range(255, 0));
                if (a == A_KEY) a = 8'h00;
                cyc(t, we, a, 8'($urandom_range(255, 0)));
                if (t) tk++;
                if (wd_reset) seen++;
            end
            send_key();
        end
        chk("R3 random service keeps quiet", seen, 0);
        chk("R4 random armed", int'(wd_armed), 1);
        begin
            int tk = 0;
            int early = 0;
            logic md = logic'($urandom_range(1, 0));
            clk12_mode = md;
            while (tk < int'(LIMIT)) begin
                logic t = ($urandom_range(3, 0) != 0);
                cyc(t, 1'b1, 8'($urandom_range(165, 0)), 8'($urandom_range(255, 0)));
                if (t) tk++;
                if (wd_reset && tk < int'(LIMIT)) early++;
            end
            chk("R5 random no early pulse", early, 0);
            chk("R5 random pulse at limit", int'(wd_reset), 1);
            drain(w);
            chk("R7 random mode width", w, exp_width(md));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule